// File: doc/BRIEF.md
# Slave-clocked serial byte port with split frame syncs

This block moves bytes over a synchronous serial link whose bit clock comes from the remote master. Each direction has its own frame-sync line, so the transmitter and receiver run independently: a pulse on the transmit sync starts one outgoing byte, and a pulse on the receive sync starts one incoming byte. The two pulse streams have no fixed relation, and one direction may carry far more bytes than the other.

The transmitter takes 16-bit half-words from a first-word-fall-through FIFO and sends each as two bytes, the upper byte first. The receiver hands every completed byte to a downstream packer with a one-cycle strobe. Two enable bits are written from the host clock domain. They pass through a synchronizer clocked by the serial clock, and the status outputs show the synchronized copies. Software therefore sees a new enable value only once it actually governs the serial logic.

Each engine is a two-state machine. TX_IDLE moves to TX_SHIFT when an accepted frame sync loads a byte. TX_SHIFT returns to TX_IDLE after its eighth bit unless a new sync arrives on that same edge, in which case it reloads and stays in TX_SHIFT. The receiver works the same way with RX_IDLE and RX_SHIFT. When the synchronized enable drops, either machine goes to its idle state at once.

Top module: `sp_byte_port`

## Requirements
- R1: During and after reset, en_status is 00, txd is 0, rx_valid is 0 and tx_pop is 0.
- R2: A value written with en_wr (bit 0 = transmit enable, bit 1 = receive enable) shows on en_status at the second rising sclk edge after the host write, and not at the first.
- R3: While an enable bit on en_status is 0, its direction ignores its frame sync: txd stays 0, tx_pop stays 0, rx_valid stays 0, no FIFO word is consumed, and the half-word position is reset so the next word starts with its upper byte.
- R4: When tx_fs is high at rising sclk edge k, txd carries the byte's bits from the most significant down, one bit after each of edges k+1 through k+8.
- R5: tx_pop is asserted, combinationally during the accepted frame sync, only for a frame that needs a new word. The upper byte of that word goes out in that frame and the lower byte in the next frame, which does not pop.
- R6: If the FIFO is empty at a frame that needs a new word, 0x00 is sent and nothing is popped. The next word later starts again with its upper byte.
- R7: When rx_fs is high at falling sclk edge m, rxd is sampled at falling edges m+1 through m+8, most significant bit first. At edge m+8, rx_byte takes the assembled byte and rx_valid is high for exactly one sclk period.
- R8: A frame sync on the edge that carries a byte's eighth bit starts the next byte with no gap, in both directions.
- R9: Transmit and receive frames at unrelated rates and counts complete correctly at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host clock for the enable register |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| en_wr | input | 1 | Host write strobe for the enable register |
| en_wdata | input | 2 | Enable value: bit 0 transmit, bit 1 receive |
| en_status | output | 2 | Synchronized enables, as in force in the serial domain |
| sclk | input | 1 | Serial bit clock from the remote master |
| tx_fs | input | 1 | Transmit frame sync, sampled on rising sclk |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_word | input | WORD_W | Head word of the transmit FIFO |
| tx_pop | output | 1 | Consumes the head word at this rising sclk edge |
| txd | output | 1 | Serial transmit data, changes on rising sclk |
| rx_fs | input | 1 | Receive frame sync, sampled on falling sclk |
| rxd | input | 1 | Serial receive data, sampled on falling sclk |
| rx_byte | output | BYTE_W | Last completed received byte |
| rx_valid | output | 1 | One-period strobe marking a new rx_byte |

## Verification
Each direction is run with frames spaced wider than a byte and with frames packed back to back. The wide spacing confirms that the bit window starts on the edge after the sync. The packed spacing separates a correct reload on the last bit edge from a design that inserts an idle cycle. Transmit streams are run with a partly full FIFO and then with a drained one, which shows whether the upper-byte/lower-byte alternation and the zero fill on empty stay in step across words. Unrelated transmit and receive periods run together to show that neither machine depends on the other's sync. Syncs sent while the port is disabled show that no word is lost.

// File: rtl/sp_pkg.sv
package sp_pkg;

    typedef enum logic {
        TX_IDLE  = 1'b0,
        TX_SHIFT = 1'b1
    } tx_state_e;

    typedef enum logic {
        RX_IDLE  = 1'b0,
        RX_SHIFT = 1'b1
    } rx_state_e;

    localparam int EN_TX_BIT = 0;
    localparam int EN_RX_BIT = 1;
    localparam int EN_W      = 2;

endpackage

// File: rtl/sp_en_sync.sv
module sp_en_sync #(
    parameter int EN_W        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic            hclk,
    input  logic            sclk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [EN_W-1:0] wdata,
    output logic [EN_W-1:0] mid,
    output logic [EN_W-1:0] live
);

    logic [EN_W-1:0] req;
    logic [EN_W-1:0] stage [SYNC_STAGES];

    // host-domain request register
    always_ff @(posedge hclk or negedge rst_n) begin
        if (!rst_n)
            req <= '0;
        else if (wr)
            req <= wdata;
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n)
            stage[0] <= '0;
        else
            stage[0] <= req;
    end

    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
        always_ff @(posedge sclk or negedge rst_n) begin
            if (!rst_n)
                stage[g] <= '0;
            else
                stage[g] <= stage[g-1];
        end
    end

    assign mid  = stage[0];
    assign live = stage[SYNC_STAGES-1];

endmodule

// File: rtl/sp_tx_engine.sv
module sp_tx_engine
    import sp_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 16
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              fs,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_data,
    output logic              fifo_pop,
    output logic              txd
);

    localparam int BPW   = WORD_W / BYTE_W;
    localparam int IDX_W = (BPW > 1) ? $clog2(BPW) : 1;
    localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

    tx_state_e         state, nxt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [IDX_W-1:0]  part;
    logic [WORD_W-1:0] held;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] next_byte;
    logic              last_bit;
    logic              load;
    logic              need_word;

    function automatic logic [BYTE_W-1:0] pick(
        input logic [WORD_W-1:0] w,
        input logic [IDX_W-1:0]  i
    );
        return w[(BPW - 1 - int'(i)) * BYTE_W +: BYTE_W];
    endfunction

    always_comb begin
        last_bit  = (state == TX_SHIFT) && (bit_cnt == CNT_W'(BYTE_W - 1));
        load      = en && fs && ((state == TX_IDLE) || last_bit);
        need_word = (part == '0);
        fifo_pop  = load && need_word && !fifo_empty;   // R5, R6
        if (need_word)
            next_byte = fifo_empty ? '0 : pick(fifo_data, '0);
        else
            next_byte = pick(held, part);
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (!en) begin
            nxt = TX_IDLE;
        end else begin
            unique case (state)
                TX_IDLE:  nxt = load ? TX_SHIFT : TX_IDLE;
                TX_SHIFT: nxt = (last_bit && !load) ? TX_IDLE : TX_SHIFT;
            endcase
        end
    end

    // state register
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n)
            state <= TX_IDLE;
        else
            state <= nxt;
    end

    // outputs and datapath
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            txd     <= 1'b0;
            shreg   <= '0;
            bit_cnt <= '0;
            part    <= '0;
            held    <= '0;
        end else if (!en) begin
            txd     <= 1'b0;
            shreg   <= '0;
            bit_cnt <= '0;
            part    <= '0;
        end else begin
            unique case (state)
                TX_IDLE: begin
                    txd <= 1'b0;
                end
                TX_SHIFT: begin
                    txd     <= shreg[BYTE_W-1];
                    shreg   <= shreg << 1;
                    bit_cnt <= bit_cnt + 1'b1;
                end
            endcase
            if (load) begin
                shreg   <= next_byte;
                bit_cnt <= '0;
                if (need_word) begin
                    if (!fifo_empty) begin
                        held <= fifo_data;
                        part <= IDX_W'(1);
                    end
                end else begin
                    part <= (part == IDX_W'(BPW - 1)) ? '0 : part + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sp_rx_engine.sv
module sp_rx_engine
    import sp_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              fs,
    input  logic              rxd,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid
);

    localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

    rx_state_e         state, nxt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] assembled;
    logic              last_bit;
    logic              start;

    always_comb begin
        last_bit  = (state == RX_SHIFT) && (bit_cnt == CNT_W'(BYTE_W - 1));
        start     = en && fs && ((state == RX_IDLE) || last_bit);
        assembled = {shreg[BYTE_W-2:0], rxd};
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (!en) begin
            nxt = RX_IDLE;
        end else begin
            unique case (state)
                RX_IDLE:  nxt = start ? RX_SHIFT : RX_IDLE;
                RX_SHIFT: nxt = (last_bit && !start) ? RX_IDLE : RX_SHIFT;
            endcase
        end
    end

    // state register, falling-edge domain
    always_ff @(negedge sclk or negedge rst_n) begin
        if (!rst_n)
            state <= RX_IDLE;
        else
            state <= nxt;
    end

    // outputs and datapath
    always_ff @(negedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else if (!en) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    bit_cnt <= '0;
                end
                RX_SHIFT: begin
                    shreg   <= assembled;
                    bit_cnt <= bit_cnt + 1'b1;
                    if (last_bit) begin
                        rx_byte  <= assembled;   // R7
                        rx_valid <= 1'b1;
                    end
                end
            endcase
            if (start)
                bit_cnt <= '0;
        end
    end

endmodule

// File: rtl/sp_byte_port.sv
module sp_byte_port
    import sp_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              hclk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic [1:0]        en_wdata,
    output logic [1:0]        en_status,
    input  logic              sclk,
    input  logic              tx_fs,
    input  logic              tx_empty,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_pop,
    output logic              txd,
    input  logic              rx_fs,
    input  logic              rxd,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid
);

    logic [EN_W-1:0] en_mid;
    logic [EN_W-1:0] en_live;

    sp_en_sync #(
        .EN_W        (EN_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_en (
        .hclk  (hclk),
        .sclk  (sclk),
        .rst_n (rst_n),
        .wr    (en_wr),
        .wdata (en_wdata),
        .mid   (en_mid),
        .live  (en_live)
    );

    assign en_status = en_live;

    sp_tx_engine #(
        .BYTE_W (BYTE_W),
        .WORD_W (WORD_W)
    ) u_tx (
        .sclk       (sclk),
        .rst_n      (rst_n),
        .en         (en_live[EN_TX_BIT]),
        .fs         (tx_fs),
        .fifo_empty (tx_empty),
        .fifo_data  (tx_word),
        .fifo_pop   (tx_pop),
        .txd        (txd)
    );

    sp_rx_engine #(
        .BYTE_W (BYTE_W)
    ) u_rx (
        .sclk     (sclk),
        .rst_n    (rst_n),
        .en       (en_live[EN_RX_BIT]),
        .fs       (rx_fs),
        .rxd      (rxd),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid)
    );

endmodule

// File: rtl/sp_byte_port_chk.sv
module sp_byte_port_chk #(
    parameter int WORD_W = 16
) (
    input logic              sclk,
    input logic              rst_n,
    input logic [1:0]        en_status,
    input logic [1:0]        en_mid,
    input logic              tx_fs,
    input logic              tx_empty,
    input logic [WORD_W-1:0] tx_word,
    input logic              tx_pop,
    input logic              txd,
    input logic              rx_valid
);

    AST_STATUS_VIA_SYNC: assert property (@(posedge sclk) disable iff (!rst_n)
        (en_status != $past(en_status)) |-> (en_status == $past(en_mid))); // R2

    AST_TXD_QUIET_OFF: assert property (@(posedge sclk) disable iff (!rst_n)
        !en_status[0] |=> (txd == 1'b0)); // R3

    AST_RX_QUIET_OFF: assert property (@(negedge sclk) disable iff (!rst_n)
        !en_status[1] |=> !rx_valid); // R3

    AST_POP_NEEDS_SYNC: assert property (@(posedge sclk) disable iff (!rst_n)
        tx_pop |-> tx_fs); // R5

    AST_POP_MSB_OUT: assert property (@(posedge sclk) disable iff (!rst_n)
        (tx_pop ##1 en_status[0]) |=> (txd == $past(tx_word[WORD_W-1], 2))); // R5

    AST_NO_POP_EMPTY: assert property (@(posedge sclk) disable iff (!rst_n)
        tx_pop |-> !tx_empty); // R6

    AST_RX_STROBE_ONE: assert property (@(negedge sclk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R7

endmodule

bind sp_byte_port sp_byte_port_chk #(
    .WORD_W (WORD_W)
) u_chk (
    .sclk      (sclk),
    .rst_n     (rst_n),
    .en_status (en_status),
    .en_mid    (en_mid),
    .tx_fs     (tx_fs),
    .tx_empty  (tx_empty),
    .tx_word   (tx_word),
    .tx_pop    (tx_pop),
    .txd       (txd),
    .rx_valid  (rx_valid)
);

// File: tb/tb_sp_byte_port.sv
module tb_sp_byte_port;

    localparam int BW = 8;
    localparam int WW = 16;
    localparam logic [23:0] VEC [0:5] = '{
        24'h1234_A5, 24'hFF00_5A, 24'h8001_80, 24'h00FF_01, 24'hC3A5_FF, 24'h7E81_00
    };

    logic          clk = 1'b0;
    logic          sclk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en_wr = 1'b0;
    logic [1:0]    en_wdata = 2'b00;
    logic [1:0]    en_status;
    logic          tx_fs = 1'b0;
    logic          tx_empty;
    logic [WW-1:0] tx_word;
    logic          tx_pop;
    logic          txd;
    logic          rx_fs = 1'b0;
    logic          rxd = 1'b0;
    logic [BW-1:0] rx_byte;
    logic          rx_valid;

    logic [WW-1:0] tx_mem [0:31];
    int            wr_cnt = 0;
    int            rd_idx = 0;
    logic [7:0]    tx_got [0:15];
    logic          tx_popped [0:15];
    logic [7:0]    rx_exp [0:15];
    int            n_chk = 0;
    int            n_fail = 0;
    int            mdl_rd = 0;
    int            mdl_part = 0;
    logic [15:0]   mdl_held = '0;
    bit            done = 1'b0;

    assign tx_word  = tx_mem[rd_idx % 32];
    assign tx_empty = (rd_idx == wr_cnt);

    always #4 clk = ~clk;
    initial begin
        #7;
        forever #20 sclk = ~sclk;
    end

    sp_byte_port dut (
        .hclk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
        .en_status(en_status), .sclk(sclk), .tx_fs(tx_fs), .tx_empty(tx_empty),
        .tx_word(tx_word), .tx_pop(tx_pop), .txd(txd), .rx_fs(rx_fs), .rxd(rxd),
        .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] w);
        tx_mem[wr_cnt % 32] = w;
        wr_cnt++;
    endtask

    task automatic write_en(input logic [1:0] v);
        @(posedge clk); #1;
        en_wr = 1'b1;
        en_wdata = v;
        @(posedge clk); #1;
        en_wr = 1'b0;
    endtask

    // tx syncs every st cycles (nt frames), rx syncs every sr cycles (nr frames)
    task automatic run_stream(input int nt, input int st, input int nr, input int sr,
                              input bit rx_on, input string tag);
        int total;
        bit pend;
        total = ((nt * st > nr * sr) ? nt * st : nr * sr) + 12;
        pend = 1'b0;
        for (int t = 0; t < total; t++) begin
            @(negedge sclk);
            if (pend) begin
                rd_idx++;
                pend = 1'b0;
            end
            if (t >= 2 && (t - 2) / st < nt && (t - 2) % st < 8)
                tx_got[(t - 2) / st][7 - ((t - 2) % st)] = txd;
            if (t % st == 0 && t / st < nt) begin
                tx_fs = 1'b1;
                #1;
                tx_popped[t / st] = tx_pop;
                pend = tx_pop;
            end else begin
                tx_fs = 1'b0;
            end
            @(posedge sclk);
            if (t >= 9 && (t - 9) % sr == 0 && (t - 9) / sr < nr) begin
                if (rx_on) begin
                    chk(rx_valid === 1'b1, tag, "rx_valid", int'(rx_valid), 1);
                    chk(rx_byte === rx_exp[(t - 9) / sr], tag, "rx_byte",
                        int'(rx_byte), int'(rx_exp[(t - 9) / sr]));
                end else begin
                    chk(rx_valid === 1'b0, "R3", "rx_valid while disabled", int'(rx_valid), 0);
                end
            end
            rx_fs = (t % sr == 0 && t / sr < nr);
            if (t >= 1 && (t - 1) / sr < nr && (t - 1) % sr < 8)
                rxd = rx_exp[(t - 1) / sr][7 - ((t - 1) % sr)];
            else
                rxd = 1'b0;
        end
        tx_fs = 1'b0;
        rx_fs = 1'b0;
    endtask

    task automatic check_tx(input int nt, input bit en_on, input string tag);
        logic [7:0] eb;
        logic       ep;
        for (int j = 0; j < nt; j++) begin
            eb = 8'h00;
            ep = 1'b0;
            if (en_on) begin
                if (mdl_part == 0) begin
                    if (mdl_rd < wr_cnt) begin
                        mdl_held = tx_mem[mdl_rd % 32];
                        eb = mdl_held[15:8];
                        ep = 1'b1;
                        mdl_rd++;
                        mdl_part = 1;
                    end
                end else begin
                    eb = mdl_held[7:0];
                    mdl_part = 0;
                end
            end
            chk(tx_got[j] === eb, tag, "tx byte", int'(tx_got[j]), int'(eb));
            chk(tx_popped[j] === ep, "R5", "tx_pop", int'(tx_popped[j]), int'(ep));
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) tx_mem[i] = '0;
        #30 rst_n = 1'b1;

        // R1 reset state
        @(negedge sclk);
        chk(en_status === 2'b00, "R1", "en_status", int'(en_status), 0);
        chk(txd === 1'b0, "R1", "txd", int'(txd), 0);
        chk(rx_valid === 1'b0, "R1", "rx_valid", int'(rx_valid), 0);
        chk(tx_pop === 1'b0, "R1", "tx_pop", int'(tx_pop), 0);

        // R3 frames ignored while disabled
        push(16'hA55A);
        rx_exp[0] = 8'h3C;
        rx_exp[1] = 8'hC3;
        run_stream(2, 10, 2, 10, 1'b0, "R3");
        check_tx(2, 1'b0, "R3");
        chk(rd_idx == 0, "R3", "fifo reads while disabled", rd_idx, 0);

        // R2 enable passes two serial stages
        write_en(2'b11);
        @(posedge sclk); #1;
        chk(en_status === 2'b00, "R2", "status after one sclk", int'(en_status), 0);
        @(posedge sclk); #1;
        chk(en_status === 2'b11, "R2", "status after two sclk", int'(en_status), 3);

        // table of words and receive bytes: R4 / R7
        for (int v = 0; v < 6; v++) begin
            push(VEC[v][23:8]);
            rx_exp[0] = VEC[v][7:0];
            run_stream(2, 11, 1, 11, 1'b1, "R7");
            check_tx(2, 1'b1, "R4");
        end

        // R6 FIFO drains: one word left, then zero fill
        run_stream(4, 9, 0, 9, 1'b1, "R6");
        check_tx(4, 1'b1, "R6");
        push(16'h1E2D);
        run_stream(3, 9, 0, 9, 1'b1, "R6");
        check_tx(3, 1'b1, "R6");

        // R8 back-to-back in both directions
        push(16'h9F60);
        push(16'h0AF5);
        push(16'hB44B);
        rx_exp[0] = 8'hE1;
        rx_exp[1] = 8'h1E;
        rx_exp[2] = 8'h96;
        run_stream(6, 8, 3, 8, 1'b1, "R8");
        check_tx(6, 1'b1, "R8");

        // R9 unrelated rates and counts
        push(16'h6C39);
        push(16'hD2A7);
        for (int i = 0; i < 6; i++) rx_exp[i] = 8'h11 * (i + 3);
        run_stream(4, 13, 6, 8, 1'b1, "R9");
        check_tx(4, 1'b1, "R9");

        // disable again: status drops, frames ignored, half-word position cleared
        write_en(2'b00);
        mdl_part = 0;
        @(posedge sclk);
        @(posedge sclk); #1;
        chk(en_status === 2'b00, "R2", "status after disable", int'(en_status), 0);
        push(16'h5511);
        rx_exp[0] = 8'hAA;
        run_stream(2, 10, 1, 10, 1'b0, "R3");
        check_tx(2, 1'b0, "R3");
        chk(rd_idx == mdl_rd, "R3", "fifo reads after disable", rd_idx, mdl_rd);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule